// File: doc/BRIEF.md
# Comparator Reference Ramp Generator

This block produces a 16-bit reference word for a comparator in peak-current-mode control. The word starts at a programmed value. It then moves down or up by a programmed step on every clock, so the comparator threshold follows a slope-compensation ramp. Software writes shadow copies of three values through a write port: the start value, the step size and a start delay.

Three event inputs each act on their rising edge only:

- A source-update strobe copies the shadows into the active registers and reloads the output.
- A period-sync trigger does the same copy and reload, then arms the ramp. The ramp begins moving once the delay countdown has run out.
- A comparator-trip status halts the ramp. A load-select input chooses whether the output reloads from the shadow start value, with a full shadow transfer, or from the active start value.

The output clamps at 0 when ramping down and at 0xFFFF when ramping up. Once it hits either bound it holds there until the next sync.

Top module: `cmp_ramp_gen`

## Requirements
- R1: After reset the output is 0, all shadow and active registers are 0 and the ramp is stopped.
- R2: Shadow writes (`wr_sel` 0 = start value, 1 = step, 2 = delay, 3 = no effect) do not change the output until an event occurs.
- R3: A source-update rising edge makes the output equal the shadow start value one cycle later and does not start a stopped ramp.
- R4: A sync rising edge loads the shadow start value into the output one cycle later and arms the ramp. With delay D, the first step happens D+1 cycles after the edge.
- R5: With `dir_up` = 0 a running ramp subtracts the active step once per clock.
- R6: With `dir_up` = 1 a running ramp adds the active step once per clock.
- R7: A trip rising edge with `trip_load_shadow` = 1 loads the shadows into the active registers, sets the output to the shadow start value and stops the ramp.
- R8: A trip rising edge with `trip_load_shadow` = 0 sets the output to the active start value, transfers no shadow and stops the ramp.
- R9: When a down step would go below 0 the output becomes 0. It stays at 0 until the next sync, even if `dir_up` changes.
- R10: When an up step would exceed 0xFFFF the output becomes 0xFFFF. It stays there until the next sync, even if `dir_up` changes.
- R11: An event input held high acts only once, on its rising edge.
- R12: When several rising edges coincide, trip wins over sync, and sync wins over source-update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Shadow write enable |
| wr_sel | input | 2 | Shadow select: 0 start, 1 step, 2 delay |
| wr_data | input | 16 | Shadow write data |
| dir_up | input | 1 | 1 = ramp up, 0 = ramp down |
| trip_load_shadow | input | 1 | Trip reload source: 1 shadow, 0 active |
| src_upd | input | 1 | Source-update strobe |
| sync_trig | input | 1 | Selected period-sync trigger |
| trip | input | 1 | Comparator-trip status |
| ramp_out | output | 16 | Reference value to the comparator |

## Verification
Every event edge is sampled at a clock edge, and its effect on `ramp_out` appears right after that same edge. A ramp with delay D therefore holds its start value for D further edges, and the first step shows on edge D+1. The bench drives inputs and samples `ramp_out` on falling clock edges. It counts the rising edges from the event edge, so each expected value is read exactly n cycles after the event. Hold and no-effect checks re-sample after extra cycles, which shows that the output did not move.

// File: rtl/cmp_ramp_gen.sv
module cmp_ramp_gen #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         dir_up,
  input  logic         trip_load_shadow,
  input  logic         src_upd,
  input  logic         sync_trig,
  input  logic         trip,
  output logic [W-1:0] ramp_out
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic         src_q, sync_q, trip_q;
  logic [W-1:0] sh_ref, sh_step, sh_dly;
  logic [W-1:0] act_ref, act_step;
  logic [W-1:0] dly_cnt, ramp;
  logic         run;

  wire ev_trip = trip & ~trip_q;
  wire ev_sync = sync_trig & ~sync_q & ~ev_trip;
  wire ev_src  = src_upd & ~src_q & ~ev_trip & ~ev_sync;
  wire load_sh = ev_src | ev_sync | (ev_trip & trip_load_shadow);
  wire no_ev   = ~(trip & ~trip_q) & ~(sync_trig & ~sync_q) & ~(src_upd & ~src_q);

  wire [W:0]   up_sum = {1'b0, ramp} + {1'b0, act_step};
  wire [W-1:0] nxt_up = up_sum[W] ? MAXV : up_sum[W-1:0];
  wire [W-1:0] nxt_dn = (ramp < act_step) ? '0 : ramp - act_step;
  wire [W-1:0] nxt    = dir_up ? nxt_up : nxt_dn;
  wire         at_bnd = dir_up ? (nxt == MAXV) : (nxt == '0);

  assign ramp_out = ramp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q    <= 1'b0;
      sync_q   <= 1'b0;
      trip_q   <= 1'b0;
      sh_ref   <= '0;
      sh_step  <= '0;
      sh_dly   <= '0;
      act_ref  <= '0;
      act_step <= '0;
      dly_cnt  <= '0;
      ramp     <= '0;
      run      <= 1'b0;
    end else begin
      src_q  <= src_upd;
      sync_q <= sync_trig;
      trip_q <= trip;
      if (wr_en) begin
        case (wr_sel)
          2'd0:    sh_ref  <= wr_data;
          2'd1:    sh_step <= wr_data;
          2'd2:    sh_dly  <= wr_data;
          default: ;
        endcase
      end
      if (load_sh) begin
        act_ref  <= sh_ref;
        act_step <= sh_step;
      end
      if (ev_trip) begin
        ramp <= trip_load_shadow ? sh_ref : act_ref;
        run  <= 1'b0;
      end else if (ev_sync) begin
        ramp    <= sh_ref;
        dly_cnt <= sh_dly;
        run     <= 1'b1;
      end else if (ev_src) begin
        ramp <= sh_ref;
      end else if (run) begin
        if (dly_cnt != '0) begin
          dly_cnt <= dly_cnt - 1'b1;
        end else begin
          ramp <= nxt;
          if (at_bnd) run <= 1'b0;
        end
      end
    end
  end

  a_r4_sync_loads: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sync |=> ramp_out == $past(sh_ref));

  a_r7_r8_trip_halts: assert property (@(posedge clk) disable iff (!rst_n)
    ev_trip ##1 no_ev |=> $stable(ramp_out));

  a_r5_down_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_up && no_ev) |=> ramp_out <= $past(ramp_out));

  a_r6_up_only: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_up && no_ev) |=> ramp_out >= $past(ramp_out));

  a_r9_floor_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_out == '0 && !dir_up && no_ev) |=> ramp_out == '0);

  a_r10_ceiling_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_out == MAXV && dir_up && no_ev) |=> ramp_out == MAXV);
endmodule

// File: tb/tb_cmp_ramp_gen.sv
module tb_cmp_ramp_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = '0;
  logic        dir_up = 1'b0;
  logic        trip_load_shadow = 1'b0;
  logic        src_upd = 1'b0;
  logic        sync_trig = 1'b0;
  logic        trip = 1'b0;
  logic [15:0] ramp_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cmp_ramp_gen #(.W(16)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .dir_up(dir_up), .trip_load_shadow(trip_load_shadow), .src_upd(src_upd),
    .sync_trig(sync_trig), .trip(trip), .ramp_out(ramp_out)
  );

  typedef struct packed {
    logic        dir;
    logic [15:0] rf;
    logic [15:0] st;
    logic [15:0] dl;
    logic [15:0] n;
    logic [15:0] ex;
  } vec_t;

  localparam vec_t VEC [0:6] = '{
    '{1'b0, 16'd1000,   16'd10, 16'd3, 16'd0,  16'd1000},
    '{1'b0, 16'd1000,   16'd10, 16'd3, 16'd3,  16'd1000},
    '{1'b0, 16'd1000,   16'd10, 16'd3, 16'd5,  16'd980},
    '{1'b1, 16'd100,    16'd7,  16'd0, 16'd4,  16'd128},
    '{1'b0, 16'd50,     16'd20, 16'd0, 16'd3,  16'd0},
    '{1'b1, 16'hFFF0,   16'd5,  16'd1, 16'd5,  16'hFFFF},
    '{1'b0, 16'd30,     16'd0,  16'd0, 16'd10, 16'd30}
  };

  task automatic check(input string tag, input logic [15:0] exp);
    checks++;
    if (ramp_out !== exp) begin
      errors++;
      $display("FAIL %s: ramp_out=%0d expected=%0d", tag, ramp_out, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic prog(input logic [15:0] rf, input logic [15:0] st, input logic [15:0] dl);
    wr(2'd0, rf);
    wr(2'd1, st);
    wr(2'd2, dl);
  endtask

  task automatic pulse(input bit s, input bit y, input bit t);
    @(negedge clk);
    src_upd = s; sync_trig = y; trip = t;
    @(negedge clk);
    src_upd = 1'b0; sync_trig = 1'b0; trip = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset output", 16'd0);

    prog(16'd1234, 16'd5, 16'd0);
    wr(2'd3, 16'd77);
    wait_n(3);
    check("R2 shadow write hidden", 16'd0);

    for (int i = 0; i < 7; i++) begin
      prog(VEC[i].rf, VEC[i].st, VEC[i].dl);
      dir_up = VEC[i].dir;
      pulse(1'b0, 1'b1, 1'b0);
      wait_n(int'(VEC[i].n));
      check($sformatf("R4/R5/R6/R9/R10 vector %0d", i), VEC[i].ex);
    end

    trip_load_shadow = 1'b0;
    pulse(1'b0, 1'b0, 1'b1);
    check("R8 trip reloads active start", 16'd30);
    wr(2'd0, 16'd500);
    wr(2'd1, 16'd9);
    pulse(1'b0, 1'b0, 1'b1);
    wait_n(2);
    check("R8 no shadow transfer", 16'd30);

    pulse(1'b1, 1'b0, 1'b0);
    check("R3 source update loads shadow", 16'd500);
    wait_n(5);
    check("R3 source update does not start", 16'd500);

    dir_up = 1'b0;
    prog(16'd1000, 16'd1, 16'd0);
    pulse(1'b0, 1'b1, 1'b0);
    wait_n(3);
    check("R5 down by step", 16'd997);
    wr(2'd0, 16'd700);
    trip_load_shadow = 1'b1;
    pulse(1'b0, 1'b0, 1'b1);
    check("R7 trip loads shadow start", 16'd700);
    wait_n(5);
    check("R7 trip stops ramp", 16'd700);

    prog(16'd5, 16'd10, 16'd0);
    dir_up = 1'b0;
    pulse(1'b0, 1'b1, 1'b0);
    wait_n(3);
    check("R9 clamp at zero", 16'd0);
    dir_up = 1'b1;
    wait_n(3);
    check("R9 hold at zero after dir change", 16'd0);
    pulse(1'b0, 1'b1, 1'b0);
    wait_n(2);
    check("R9 sync releases hold, R6 up", 16'd25);

    prog(16'hFFFE, 16'd4, 16'd0);
    dir_up = 1'b1;
    pulse(1'b0, 1'b1, 1'b0);
    wait_n(2);
    check("R10 clamp at max", 16'hFFFF);
    dir_up = 1'b0;
    wait_n(3);
    check("R10 hold at max after dir change", 16'hFFFF);

    prog(16'd100, 16'd1, 16'd0);
    dir_up = 1'b0;
    @(negedge clk);
    sync_trig = 1'b1;
    wait_n(6);
    check("R11 held sync acts once", 16'd95);
    sync_trig = 1'b0;

    prog(16'd40, 16'd1, 16'd0);
    trip_load_shadow = 1'b1;
    pulse(1'b1, 1'b1, 1'b1);
    wait_n(4);
    check("R12 trip beats sync and source", 16'd40);
    pulse(1'b1, 1'b1, 1'b0);
    wait_n(3);
    check("R12 sync beats source", 16'd37);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule